// File: doc/BRIEF.md
# Speculative Load Fault Checker

This block examines a speculative load during the cycle it is issued and decides whether the load may go ahead. It adds the base register value to either an index register value or a signed immediate to form the effective address. It then checks the address against the natural alignment of the access size, and checks whether the destination register number suits a multi-register load. A fault does not trap. It is recorded in a poison bit for the destination register. The integer register file and the float register file each have their own set of 64 poison bits.

When no fault is found, poison moves from the source registers to the destination. A load whose base register is poisoned, or whose index register is poisoned while the index is in use, is suppressed and poisons its destination. When the caller enables fault logging, the block also claims the lowest free syndrome slot among the first N slots. It reports what it writes into that slot, together with the effective address. If logging is enabled and no slot is free, the block raises a fatal indication.

All results appear as registered outputs in the cycle after the request strobe.

Top module: `nel_load_checker`

## Requirements
- R1: The effective address is base value plus index value when `req_use_idx` is 1, and base value plus the signed immediate when it is 0. It is reported on `syn_addr`.
- R2: Size codes are 0 byte, 1 halfword, 2 word, 3 doubleword and 4 quadword. A byte access never faults. The other sizes fault when the effective address has any of its low 1, 2, 3 or 4 bits set, in that order of size.
- R3: A doubleword load has a register fault when the target number is odd. A quadword load has a register fault when the target number is not a multiple of 4. Smaller sizes never have a register fault.
- R4: When either fault is present, the target's poison bit is written to 1 and `resp_load` is 1.
- R5: When no fault is present, the target's poison bit becomes the base register's poison bit, ORed with the index register's poison bit only when `req_use_idx` is 1. If the result is 1, `resp_load` is 0.
- R6: A fault-free load whose sources are clean writes the target's poison bit to 0, and `resp_load` is 1.
- R7: The integer and float poison sets (`req_fp` 0 and 1) are independent. Reads and writes use only the set that `req_fp` selects.
- R8: A syndrome slot is written only when `log_valid` and `log_en` are both 1.
- R9: The slot written is the lowest-indexed slot not yet claimed since reset whose index is below `log_count`.
- R10: A syndrome write reports the slot index, the target register, the size code, the float flag, `syn_reg_mis` equal to the register fault and `syn_mem_mis` equal to the memory fault.
- R11: If logging is active and no slot qualifies, `fatal` is 1 and no syndrome write happens. The poison update still takes place.
- R12: Size codes 5 to 7 raise `fatal`. They write neither poison nor syndrome, and `resp_load` is 0.
- R13: `resp_valid` and all write strobes pulse exactly one cycle after `req_valid`, and they are 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_fp | input | 1 | 1 = float register file |
| req_size | input | 3 | Access size code |
| req_base_reg | input | 6 | Base register number |
| req_base_val | input | 32 | Base register value |
| req_use_idx | input | 1 | Use index register instead of immediate |
| req_idx_reg | input | 6 | Index register number |
| req_idx_val | input | 32 | Index register value |
| req_imm | input | 32 | Signed immediate displacement |
| req_tgt_reg | input | 6 | Target register number |
| log_valid | input | 1 | Logging control is valid |
| log_en | input | 1 | Logging enable |
| log_count | input | 4 | Number of syndrome slots searched |
| resp_valid | output | 1 | Result strobe |
| resp_load | output | 1 | 1 = perform the load |
| flag_we | output | 1 | Poison bit write strobe |
| flag_fp | output | 1 | File of the poison write |
| flag_idx | output | 6 | Register of the poison write |
| flag_val | output | 1 | Value written |
| syn_we | output | 1 | Syndrome write strobe |
| syn_idx | output | 3 | Syndrome slot index |
| syn_drn | output | 6 | Target register recorded |
| syn_size | output | 3 | Size code recorded |
| syn_fp | output | 1 | Float flag recorded |
| syn_reg_mis | output | 1 | Register misalignment code |
| syn_mem_mis | output | 1 | Memory misalignment code |
| syn_addr | output | 32 | Effective address recorded |
| fatal | output | 1 | No free slot, or undefined size |

## Verification
Every size is driven at both an aligned address and a misaligned address. This separates the per-size alignment masks, and odd and non-multiple-of-4 targets isolate the register check. Chains of loads show how poison moves between requests. A poisoned base suppresses the load. A poisoned index suppresses it only while the index is in use. A clean load clears a poisoned target. A float load that reads an integer-poisoned register number is not suppressed. Logging runs consume slots in order until the count limit raises fatal. Negative immediates and index-mode addresses pin down the address sum.

// File: rtl/nel_pkg.sv
// Shared types for the speculative load fault checker.
// Assumes nothing beyond the size encoding below.
package nel_pkg;
    typedef enum logic [2:0] {
        SZ_BYTE  = 3'd0,
        SZ_HALF  = 3'd1,
        SZ_WORD  = 3'd2,
        SZ_DWORD = 3'd3,
        SZ_QWORD = 3'd4
    } acc_size_e;
endpackage

// File: rtl/nel_addr_check.sv
// Forms the effective address and classifies alignment faults.
// Purely combinational; undefined size codes raise bad_size.
module nel_addr_check
    import nel_pkg::*;
#(
    parameter int AW = 32,
    parameter int RW = 6
) (
    input  logic [2:0]    size,
    input  logic [AW-1:0] base_val,
    input  logic          use_idx,
    input  logic [AW-1:0] idx_val,
    input  logic [AW-1:0] imm,
    input  logic [RW-1:0] tgt_reg,
    output logic [AW-1:0] ea,
    output logic          mem_mis,
    output logic          reg_mis,
    output logic          bad_size
);
    // Address sum: index register or immediate displacement.
    always_comb begin
        ea = base_val + (use_idx ? idx_val : imm);
    end

    // Fault classification by access size.
    always_comb begin
        mem_mis  = 1'b0;
        reg_mis  = 1'b0;
        bad_size = 1'b0;
        case (size)
            SZ_BYTE:  ;
            SZ_HALF:  mem_mis = ea[0];
            SZ_WORD:  mem_mis = |ea[1:0];
            SZ_DWORD: begin
                mem_mis = |ea[2:0];
                reg_mis = tgt_reg[0];
            end
            SZ_QWORD: begin
                mem_mis = |ea[3:0];
                reg_mis = |tgt_reg[1:0];
            end
            default:  bad_size = 1'b1;
        endcase
    end
endmodule

// File: rtl/nel_flag_bank.sv
// One register file's poison bits, stored as WORD_W-bit words.
// Assumes NUM_REGS is a multiple of WORD_W, with at least two words.
module nel_flag_bank #(
    parameter int NUM_REGS = 64,
    parameter int WORD_W   = 32,
    localparam int RW      = $clog2(NUM_REGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [RW-1:0] wr_idx,
    input  logic          wr_val,
    input  logic [RW-1:0] rd_a_idx,
    input  logic [RW-1:0] rd_b_idx,
    output logic          rd_a,
    output logic          rd_b
);
    localparam int NWORDS = NUM_REGS / WORD_W;
    localparam int BW     = $clog2(WORD_W);
    localparam int WSW    = RW - BW;

    logic [NUM_REGS-1:0] flat;

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        logic [WORD_W-1:0] bits;
        // Word storage: update the addressed bit when this word is selected.
        always_ff @(posedge clk) begin
            if (!rst_n)
                bits <= '0;
            else if (we && wr_idx[RW-1:BW] == WSW'(w))
                bits[wr_idx[BW-1:0]] <= wr_val;
        end
        assign flat[w*WORD_W +: WORD_W] = bits;
    end

    assign rd_a = flat[rd_a_idx];
    assign rd_b = flat[rd_b_idx];
endmodule

// File: rtl/nel_syn_alloc.sv
// Tracks which syndrome slots are claimed and picks the lowest free slot
// whose index is below the count limit. Slots are released only by reset.
module nel_syn_alloc #(
    parameter int NUM_SYN = 8,
    localparam int SW     = $clog2(NUM_SYN),
    localparam int CW     = $clog2(NUM_SYN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] count,
    input  logic          claim,
    output logic          found,
    output logic [SW-1:0] idx
);
    logic [NUM_SYN-1:0] used;

    // Priority search, lowest index wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_SYN - 1; i >= 0; i--) begin
            if (!used[i] && i < int'(count)) begin
                found = 1'b1;
                idx   = SW'(i);
            end
        end
    end

    for (genvar g = 0; g < NUM_SYN; g++) begin : g_slot
        // Slot occupancy: set when claimed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                used[g] <= 1'b0;
            else if (claim && found && idx == SW'(g))
                used[g] <= 1'b1;
        end
    end
endmodule

// File: rtl/nel_load_checker.sv
// Top level: checks a speculative load, updates the poison bits of the
// selected file, claims a syndrome slot when logging, and registers all
// results for one cycle after req_valid.
module nel_load_checker
    import nel_pkg::*;
#(
    parameter int AW       = 32,
    parameter int NUM_REGS = 64,
    parameter int WORD_W   = 32,
    parameter int NUM_SYN  = 8,
    localparam int RW      = $clog2(NUM_REGS),
    localparam int SW      = $clog2(NUM_SYN),
    localparam int CW      = $clog2(NUM_SYN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_fp,
    input  logic [2:0]    req_size,
    input  logic [RW-1:0] req_base_reg,
    input  logic [AW-1:0] req_base_val,
    input  logic          req_use_idx,
    input  logic [RW-1:0] req_idx_reg,
    input  logic [AW-1:0] req_idx_val,
    input  logic [AW-1:0] req_imm,
    input  logic [RW-1:0] req_tgt_reg,
    input  logic          log_valid,
    input  logic          log_en,
    input  logic [CW-1:0] log_count,
    output logic          resp_valid,
    output logic          resp_load,
    output logic          flag_we,
    output logic          flag_fp,
    output logic [RW-1:0] flag_idx,
    output logic          flag_val,
    output logic          syn_we,
    output logic [SW-1:0] syn_idx,
    output logic [RW-1:0] syn_drn,
    output logic [2:0]    syn_size,
    output logic          syn_fp,
    output logic          syn_reg_mis,
    output logic          syn_mem_mis,
    output logic [AW-1:0] syn_addr,
    output logic          fatal
);
    logic [AW-1:0] ea;
    logic          mem_mis, reg_mis, bad_size;
    logic [1:0]    rd_base, rd_idx;
    logic          src_flag, fault, new_flag, do_load;
    logic          log_on, slot_found, want_flag, want_syn, want_fatal;
    logic [SW-1:0] slot_idx;

    nel_addr_check #(.AW(AW), .RW(RW)) u_addr (
        .size     (req_size),
        .base_val (req_base_val),
        .use_idx  (req_use_idx),
        .idx_val  (req_idx_val),
        .imm      (req_imm),
        .tgt_reg  (req_tgt_reg),
        .ea       (ea),
        .mem_mis  (mem_mis),
        .reg_mis  (reg_mis),
        .bad_size (bad_size)
    );

    // Bank 0 holds integer poison bits, bank 1 float.
    for (genvar b = 0; b < 2; b++) begin : g_bank
        nel_flag_bank #(.NUM_REGS(NUM_REGS), .WORD_W(WORD_W)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .we       (want_flag && (req_fp == 1'(b))),
            .wr_idx   (req_tgt_reg),
            .wr_val   (new_flag),
            .rd_a_idx (req_base_reg),
            .rd_b_idx (req_idx_reg),
            .rd_a     (rd_base[b]),
            .rd_b     (rd_idx[b])
        );
    end

    nel_syn_alloc #(.NUM_SYN(NUM_SYN)) u_alloc (
        .clk   (clk),
        .rst_n (rst_n),
        .count (log_count),
        .claim (want_syn),
        .found (slot_found),
        .idx   (slot_idx)
    );

    // Decision logic: poison propagation, suppression and logging.
    always_comb begin
        fault      = mem_mis | reg_mis;
        src_flag   = rd_base[req_fp] | (req_use_idx & rd_idx[req_fp]);
        new_flag   = fault | src_flag;
        do_load    = !bad_size && (fault || !src_flag);
        log_on     = log_valid & log_en;
        want_flag  = req_valid & !bad_size;
        want_syn   = want_flag & log_on & slot_found;
        want_fatal = req_valid & (bad_size | (log_on & !slot_found));
    end

    // Output registers: strobes pulse for one cycle, payload follows.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid  <= 1'b0;
            resp_load   <= 1'b0;
            flag_we     <= 1'b0;
            flag_fp     <= 1'b0;
            flag_idx    <= '0;
            flag_val    <= 1'b0;
            syn_we      <= 1'b0;
            syn_idx     <= '0;
            syn_drn     <= '0;
            syn_size    <= '0;
            syn_fp      <= 1'b0;
            syn_reg_mis <= 1'b0;
            syn_mem_mis <= 1'b0;
            syn_addr    <= '0;
            fatal       <= 1'b0;
        end else begin
            resp_valid <= req_valid;
            flag_we    <= want_flag;
            syn_we     <= want_syn;
            fatal      <= want_fatal;
            if (req_valid) begin
                resp_load   <= do_load;
                flag_fp     <= req_fp;
                flag_idx    <= req_tgt_reg;
                flag_val    <= new_flag;
                syn_idx     <= slot_idx;
                syn_drn     <= req_tgt_reg;
                syn_size    <= req_size;
                syn_fp      <= req_fp;
                syn_reg_mis <= reg_mis;
                syn_mem_mis <= mem_mis;
                syn_addr    <= ea;
            end
        end
    end
endmodule

// File: rtl/nel_load_checker_sva.sv
// Temporal checks for nel_load_checker, attached with bind below.
module nel_load_checker_sva #(
    parameter int AW = 32,
    parameter int RW = 6,
    parameter int SW = 3,
    parameter int CW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_fp,
    input logic [AW-1:0] req_base_val,
    input logic          req_use_idx,
    input logic [AW-1:0] req_idx_val,
    input logic [AW-1:0] req_imm,
    input logic [RW-1:0] req_tgt_reg,
    input logic          log_valid,
    input logic          log_en,
    input logic [CW-1:0] log_count,
    input logic          resp_valid,
    input logic          resp_load,
    input logic          flag_we,
    input logic          flag_val,
    input logic [RW-1:0] flag_idx,
    input logic          syn_we,
    input logic [SW-1:0] syn_idx,
    input logic [RW-1:0] syn_drn,
    input logic          syn_fp,
    input logic [AW-1:0] syn_addr,
    input logic          fatal
);
    // R13
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);
    // R13
    resp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !resp_valid && !flag_we && !syn_we && !fatal);
    // R11
    fatal_excl_syn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fatal |-> !syn_we);
    // R8
    syn_needs_log_chk: assert property (@(posedge clk) disable iff (!rst_n)
        syn_we |-> $past(log_valid && log_en));
    // R5
    suppress_poisons_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && !resp_load && !fatal |-> flag_we && flag_val);
    // R4
    flag_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |-> flag_idx == $past(req_tgt_reg));
    // R10
    syn_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        syn_we |-> syn_drn == $past(req_tgt_reg) && syn_fp == $past(req_fp));
    // R9
    syn_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        syn_we |-> 32'(syn_idx) < 32'($past(log_count)));
    // R1
    syn_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        syn_we |-> syn_addr == $past(req_base_val +
                                     (req_use_idx ? req_idx_val : req_imm)));
endmodule

bind nel_load_checker nel_load_checker_sva #(
    .AW(AW), .RW(RW), .SW(SW), .CW(CW)
) u_sva (.*);

// File: tb/tb_nel_load_checker.sv
`timescale 1ns/1ps
module tb_nel_load_checker;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        req_valid = 0, req_fp = 0, req_use_idx = 0;
    logic [2:0]  req_size = 0;
    logic [5:0]  req_base_reg = 0, req_idx_reg = 0, req_tgt_reg = 0;
    logic [31:0] req_base_val = 0, req_idx_val = 0, req_imm = 0;
    logic        log_valid = 0, log_en = 0;
    logic [3:0]  log_count = 0;
    logic        resp_valid, resp_load, flag_we, flag_fp, flag_val;
    logic [5:0]  flag_idx, syn_drn;
    logic        syn_we, syn_fp, syn_reg_mis, syn_mem_mis, fatal;
    logic [2:0]  syn_idx, syn_size;
    logic [31:0] syn_addr;
    int checks = 0, fails = 0;

    always #10 clk = ~clk;

    nel_load_checker dut (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        req_valid = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
    endtask

    // One request, results sampled at the next falling edge.
    task automatic load(input logic fp, input logic [2:0] sz,
                        input logic [5:0] breg, input logic [31:0] bval,
                        input logic uidx, input logic [5:0] ireg,
                        input logic [31:0] ival, input logic [31:0] imm,
                        input logic [5:0] tgt);
        @(negedge clk);
        req_valid = 1; req_fp = fp; req_size = sz;
        req_base_reg = breg; req_base_val = bval;
        req_use_idx = uidx; req_idx_reg = ireg; req_idx_val = ival;
        req_imm = imm; req_tgt_reg = tgt;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic t_reset_state();
        do_reset();
        check("R13 idle", {resp_valid, flag_we, syn_we, fatal}, 0);
        load(0, 2, 1, 32'h100, 0, 0, 0, 0, 2);
        check("R6 clean word", {resp_valid, resp_load, flag_we, flag_val}, 4'b1110);
        @(negedge clk);
        check("R13 pulse", resp_valid, 0);
    endtask

    task automatic t_alignment();
        logic [31:0] masks[5];
        masks = '{0, 1, 3, 7, 15};
        do_reset();
        for (int s = 0; s < 5; s++) begin
            for (int off = 0; off < 16; off += 1) begin
                load(0, 3'(s), 1, 32'h1000, 0, 0, 0, 32'(off), 8);
                check("R2 mem mask", {flag_val, resp_load},
                      {((off & masks[s]) != 0), 1'b1});
            end
        end
    endtask

    task automatic t_regpair();
        do_reset();
        log_valid = 1; log_en = 1; log_count = 8;
        load(0, 3, 1, 32'h40, 0, 0, 0, 0, 5);
        check("R3 dword odd", {flag_val, syn_reg_mis, syn_mem_mis}, 3'b110);
        load(0, 4, 1, 32'h40, 0, 0, 0, 0, 6);
        check("R3 qword not x4", {flag_val, syn_reg_mis}, 2'b11);
        load(0, 4, 1, 32'h40, 0, 0, 0, 0, 12);
        check("R3 qword ok", {flag_val, syn_reg_mis}, 2'b00);
        load(0, 2, 1, 32'h40, 0, 0, 0, 0, 7);
        check("R3 word odd tgt", {flag_val, syn_reg_mis}, 2'b00);
        load(0, 3, 1, 32'h44, 0, 0, 0, 0, 9);
        check("R4 both faults load", {flag_val, resp_load, syn_reg_mis, syn_mem_mis}, 4'b1111);
        log_valid = 0; log_en = 0;
    endtask

    task automatic t_propagate();
        do_reset();
        load(0, 1, 1, 32'h1, 0, 0, 0, 0, 10);          // poison r10
        check("R4 half fault", {flag_val, resp_load}, 2'b11);
        load(0, 2, 10, 32'h200, 0, 0, 0, 0, 11);
        check("R5 base poisoned", {flag_val, resp_load}, 2'b10);
        load(0, 2, 1, 32'h200, 1, 10, 32'h4, 0, 12);
        check("R5 index poisoned", {flag_val, resp_load}, 2'b10);
        load(0, 2, 1, 32'h200, 0, 10, 32'h4, 0, 13);
        check("R5 index unused", {flag_val, resp_load}, 2'b01);
        load(0, 2, 1, 32'h200, 0, 0, 0, 0, 10);        // clear r10
        check("R6 clear target", {flag_val, resp_load}, 2'b01);
        load(0, 2, 10, 32'h200, 0, 0, 0, 0, 14);
        check("R6 cleared source", {flag_val, resp_load}, 2'b01);
    endtask

    task automatic t_files();
        do_reset();
        load(0, 1, 1, 32'h3, 0, 0, 0, 0, 20);          // int r20 poisoned
        load(1, 2, 20, 32'h300, 0, 0, 0, 0, 21);
        check("R7 float unaffected", {flag_fp, flag_val, resp_load}, 3'b101);
        load(0, 2, 20, 32'h300, 0, 0, 0, 0, 22);
        check("R7 int poisoned", {flag_fp, flag_val, resp_load}, 3'b010);
    endtask

    task automatic t_logging();
        do_reset();
        log_valid = 0; log_en = 1; log_count = 8;
        load(0, 2, 1, 32'h2, 0, 0, 0, 0, 3);
        check("R8 invalid ctl", {syn_we, fatal}, 0);
        log_valid = 1; log_en = 0;
        load(0, 2, 1, 32'h2, 0, 0, 0, 0, 3);
        check("R8 disabled", {syn_we, fatal}, 0);
        log_en = 1; log_count = 2;
        load(1, 3, 2, 32'h1000, 1, 3, 32'h10, 0, 8);
        check("R9 slot0", {syn_we, syn_idx}, 4'b1000);
        check("R1 index addr", syn_addr, 32'h1010);
        check("R10 fields", {syn_drn, syn_size, syn_fp, syn_reg_mis, syn_mem_mis},
              {6'd8, 3'd3, 1'b1, 1'b0, 1'b0});
        load(0, 0, 2, 32'h1000, 0, 0, 0, 32'hFFFFFFFD, 9);
        check("R9 slot1", {syn_we, syn_idx}, 4'b1001);
        check("R1 neg imm", syn_addr, 32'h0FFD);
        load(0, 1, 2, 32'h1001, 0, 0, 0, 0, 16);
        check("R11 full fatal", {syn_we, fatal}, 2'b01);
        check("R11 flag still set", {flag_we, flag_val}, 2'b11);
        log_count = 3;
        load(0, 2, 2, 32'h1000, 0, 0, 0, 0, 17);
        check("R9 slot2 after raise", {syn_we, syn_idx, fatal}, 5'b10100);
        log_valid = 0; log_en = 0;
    endtask

    task automatic t_bad_size();
        do_reset();
        log_valid = 1; log_en = 1; log_count = 8;
        load(0, 5, 1, 32'h0, 0, 0, 0, 0, 4);
        check("R12 bad size", {fatal, flag_we, syn_we, resp_load}, 4'b1000);
        load(0, 7, 1, 32'h0, 0, 0, 0, 0, 4);
        check("R12 bad size 7", {fatal, flag_we, syn_we, resp_load}, 4'b1000);
        log_valid = 0; log_en = 0;
    endtask

    initial begin
        #(20 * 20000);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_reset_state();
        t_alignment();
        t_regpair();
        t_propagate();
        t_files();
        t_logging();
        t_bad_size();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule